// File: doc/BRIEF.md
# Display Power Rail Start-up Sequencer

This block brings up a multi-rail display power supply in six timed phases. Each phase runs a digital ramp made of a fast segment and then a slow segment, and the ramp ends in a peak event. The ramp stands in for the charging of an external delay capacitor. At each peak the block either moves on to the next phase or, if a check has failed, latches off. Each phase tests its own set of fault and status flags, and the tests are sampled only during the slow segment. The check for phase six is taken on the cycle of its final peak.

Once all six phases have passed, the block enters a monitoring state. A fault that persists there runs a timeout counter, and the block trips when the counter reaches its limit. A fault that clears in time resets the counter to zero, so short glitches do not cause a shutdown. A latched fault drops every rail and opens the input protection switch, but keeps the reference enabled. Only dropping enable or losing the input supply clears the latch.

Top module: `pwr_seq`

## Requirements
- R1: While `en_i` or `uvlo_ok_i` is low, the block is idle. In idle, every enable output is 0, `pg_no` and `dly_gate_no` are 1, and `fault_o` is 0. The sequence starts on the first clock edge that sees both inputs high.
- R2: Each phase lasts exactly FAST_CYC+SLOW_CYC cycles. There are six phases, and the monitoring state follows the sixth peak when no check has failed.
- R3: In phase 1, `fault_i` high during the slow segment causes a latch-off. `ref_en_o` goes to 1 after the first peak.
- R4: In phase 2, `ref_good_i` low or `otemp_i` high during the slow segment causes a latch-off. `pg_no` goes to 0 after the second peak.
- R5: `boost_en_o` is 1 from the start of phase 3 onward. `soft_start_o` is 1 only during phase 3. In phases 3 to 5, `fault_i` high during the slow segment causes a latch-off.
- R6: `neg_en_o` is 1 after the fourth peak. `dly_gate_no` is 0 after the fifth peak.
- R7: `pos_en_o` is 1 from the start of phase 6. On the phase-6 peak cycle, `fault_i` high or any of the boost, negative, positive or delayed rail-good inputs low causes a latch-off.
- R8: After a latch-off, `fault_o`=1, all rail enables and `soft_start_o` are 0, and `pg_no` and `dly_gate_no` are 1. `ref_en_o` keeps its value. The state holds until `en_i` or `uvlo_ok_i` goes low.
- R9: In the monitoring state, the fault condition is `fault_i`, `otemp_i`, or any good input low. If it holds for TRIP_CYC consecutive cycles, the block latches off. A run of fewer cycles resets the timeout to zero.
- R10: Dropping `en_i` or `uvlo_ok_i` sends the block to idle on the next edge from any state. This clears the latch and `ref_en_o`.
- R11: Fault flags during the fast segment of a phase have no effect.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous active-low reset |
| en_i | input | 1 | Sequencer enable |
| uvlo_ok_i | input | 1 | Input supply above lockout threshold |
| fault_i | input | 1 | Generic fault flag |
| ref_good_i | input | 1 | Reference in regulation |
| otemp_i | input | 1 | Over-temperature |
| boost_good_i | input | 1 | Boost rail good |
| neg_good_i | input | 1 | Negative rail good |
| pos_good_i | input | 1 | Positive rail good |
| dly_good_i | input | 1 | Delayed output good |
| ref_en_o | output | 1 | Reference enable |
| pg_no | output | 1 | Input protection gate, active low |
| boost_en_o | output | 1 | Boost rail enable |
| soft_start_o | output | 1 | Boost soft-start window |
| neg_en_o | output | 1 | Negative rail enable |
| dly_gate_no | output | 1 | Delayed output gate, active low |
| pos_en_o | output | 1 | Positive rail enable |
| fault_o | output | 1 | Latched fault |

## Verification
Clean start-ups show the exact cycle of every peak and rail step. Single-flag faults placed in the fast segment and then in the slow segment of chosen phases separate a check that is windowed from one that is always live. They also show that each phase tests only its own flags. Monitor faults of nine cycles and of ten cycles tell a correct trip threshold from an off-by-one. Random episodes mix fault densities with enable and lockout drops, to probe latch clearing and restart from every state.

// File: rtl/pwr_seq_pkg.sv
package pwr_seq_pkg;
  typedef enum logic [1:0] {
    ST_IDLE  = 2'd0,
    ST_RAMP  = 2'd1,
    ST_RUN   = 2'd2,
    ST_LATCH = 2'd3
  } seq_state_e;

  localparam int unsigned NUM_PHASES = 6;
  localparam int unsigned PH_W = $clog2(NUM_PHASES + 1);
endpackage

// File: rtl/ramp_timer.sv
module ramp_timer #(
  parameter int unsigned FAST_CYC = 1000,
  parameter int unsigned SLOW_CYC = 4000
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic run_i,
  output logic slow_o,
  output logic peak_o
);
  localparam int unsigned LEN = FAST_CYC + SLOW_CYC;
  localparam int unsigned W   = $clog2(LEN + 1);

  logic [W-1:0] cnt_q;

  assign slow_o = (cnt_q >= W'(FAST_CYC));
  assign peak_o = (cnt_q == W'(LEN - 1));

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)               cnt_q <= '0;
    else if (!run_i || peak_o) cnt_q <= '0;
    else                       cnt_q <= cnt_q + 1'b1;
  end
endmodule

// File: rtl/fault_timer.sv
module fault_timer #(
  parameter int unsigned TRIP_CYC = 2500000
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic run_i,
  input  logic fault_i,
  output logic trip_o
);
  localparam int unsigned W = $clog2(TRIP_CYC + 1);

  logic [W-1:0] cnt_q;

  assign trip_o = run_i && fault_i && (cnt_q == W'(TRIP_CYC - 1));

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)                          cnt_q <= '0;
    else if (!run_i || !fault_i || trip_o) cnt_q <= '0;
    else                                  cnt_q <= cnt_q + 1'b1;
  end
endmodule

// File: rtl/phase_check.sv
module phase_check
  import pwr_seq_pkg::*;
(
  input  logic [PH_W-1:0] phase_i,
  input  logic            fault_i,
  input  logic            ref_good_i,
  input  logic            otemp_i,
  input  logic            rails_good_i,
  output logic            fail_o,
  output logic            mon_fail_o
);
  always_comb begin
    unique case (phase_i)
      PH_W'(1): fail_o = fault_i;
      PH_W'(2): fail_o = !ref_good_i || otemp_i;
      PH_W'(6): fail_o = fault_i || !rails_good_i;
      default:  fail_o = fault_i;
    endcase
  end

  assign mon_fail_o = fault_i || otemp_i || !ref_good_i || !rails_good_i;
endmodule

// File: rtl/pwr_seq.sv
module pwr_seq
  import pwr_seq_pkg::*;
#(
  parameter int unsigned FAST_CYC = 1000,
  parameter int unsigned SLOW_CYC = 4000,
  parameter int unsigned TRIP_CYC = 2500000
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic en_i,
  input  logic uvlo_ok_i,
  input  logic fault_i,
  input  logic ref_good_i,
  input  logic otemp_i,
  input  logic boost_good_i,
  input  logic neg_good_i,
  input  logic pos_good_i,
  input  logic dly_good_i,
  output logic ref_en_o,
  output logic pg_no,
  output logic boost_en_o,
  output logic soft_start_o,
  output logic neg_en_o,
  output logic dly_gate_no,
  output logic pos_en_o,
  output logic fault_o
);
  localparam logic [PH_W-1:0] LAST_PH = PH_W'(NUM_PHASES);

  seq_state_e      state_q;
  logic [PH_W-1:0] phase_q;
  logic            ref_q;
  logic            slow_w, peak_w, trip_w, ph_fail_w, mon_fail_w, rails_good_w;
  logic            chk_fail_w, go_w;

  assign go_w         = en_i && uvlo_ok_i;
  assign rails_good_w = boost_good_i && neg_good_i && pos_good_i && dly_good_i;

  ramp_timer #(.FAST_CYC(FAST_CYC), .SLOW_CYC(SLOW_CYC)) i_ramp (
    .clk_i (clk_i),
    .rst_ni(rst_ni),
    .run_i (state_q == ST_RAMP),
    .slow_o(slow_w),
    .peak_o(peak_w)
  );

  phase_check i_chk_sel (
    .phase_i     (phase_q),
    .fault_i     (fault_i),
    .ref_good_i  (ref_good_i),
    .otemp_i     (otemp_i),
    .rails_good_i(rails_good_w),
    .fail_o      (ph_fail_w),
    .mon_fail_o  (mon_fail_w)
  );

  fault_timer #(.TRIP_CYC(TRIP_CYC)) i_trip (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .run_i  (state_q == ST_RUN),
    .fault_i(mon_fail_w),
    .trip_o (trip_w)
  );

  // last phase is checked at its peak only, the others over the slow segment
  assign chk_fail_w = ph_fail_w && ((phase_q == LAST_PH) ? peak_w : slow_w);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      state_q <= ST_IDLE;
      phase_q <= PH_W'(1);
      ref_q   <= 1'b0;
    end else if (!go_w) begin
      state_q <= ST_IDLE;
      phase_q <= PH_W'(1);
      ref_q   <= 1'b0;
    end else begin
      unique case (state_q)
        ST_IDLE: begin
          state_q <= ST_RAMP;
          phase_q <= PH_W'(1);
        end
        ST_RAMP: begin
          if (chk_fail_w) begin
            state_q <= ST_LATCH;
          end else if (peak_w) begin
            if (phase_q == PH_W'(1)) ref_q <= 1'b1;
            if (phase_q == LAST_PH) state_q <= ST_RUN;
            else                    phase_q <= phase_q + 1'b1;
          end
        end
        ST_RUN:   if (trip_w) state_q <= ST_LATCH;
        ST_LATCH: state_q <= ST_LATCH;
        default:  state_q <= ST_IDLE;
      endcase
    end
  end

  logic live_w;
  assign live_w = (state_q == ST_RUN) || (state_q == ST_RAMP);

  assign ref_en_o     = ref_q;
  assign pg_no        = !(live_w && (state_q == ST_RUN || phase_q >= PH_W'(3)));
  assign boost_en_o   = live_w && (state_q == ST_RUN || phase_q >= PH_W'(3));
  assign soft_start_o = (state_q == ST_RAMP) && (phase_q == PH_W'(3));
  assign neg_en_o     = live_w && (state_q == ST_RUN || phase_q >= PH_W'(5));
  assign dly_gate_no  = !(live_w && (state_q == ST_RUN || phase_q >= PH_W'(6)));
  assign pos_en_o     = live_w && (state_q == ST_RUN || phase_q >= PH_W'(6));
  assign fault_o      = (state_q == ST_LATCH);
endmodule

// File: rtl/pwr_seq_chk.sv
module pwr_seq_chk (
  input logic clk_i,
  input logic rst_ni,
  input logic en_i,
  input logic uvlo_ok_i,
  input logic ref_en_o,
  input logic pg_no,
  input logic boost_en_o,
  input logic soft_start_o,
  input logic neg_en_o,
  input logic dly_gate_no,
  input logic pos_en_o,
  input logic fault_o
);
  p_idle_off_r1: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!en_i || !uvlo_ok_i) |=> (!boost_en_o && !neg_en_o && !pos_en_o && pg_no
                               && dly_gate_no && !fault_o && !ref_en_o));

  p_latch_off_r8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    fault_o |-> (pg_no && dly_gate_no && !boost_en_o && !neg_en_o && !pos_en_o && !soft_start_o));

  p_latch_hold_r8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (fault_o && en_i && uvlo_ok_i) |=> (fault_o && $stable(ref_en_o)));

  p_pg_after_ref_r4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !pg_no |-> ref_en_o);

  p_soft_start_r5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    soft_start_o |-> (boost_en_o && !neg_en_o));

  p_neg_order_r6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    neg_en_o |-> (boost_en_o && !pg_no));

  p_pos_order_r7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    pos_en_o |-> (neg_en_o && !dly_gate_no));
endmodule

bind pwr_seq pwr_seq_chk i_pwr_seq_chk (
  .clk_i       (clk_i),
  .rst_ni      (rst_ni),
  .en_i        (en_i),
  .uvlo_ok_i   (uvlo_ok_i),
  .ref_en_o    (ref_en_o),
  .pg_no       (pg_no),
  .boost_en_o  (boost_en_o),
  .soft_start_o(soft_start_o),
  .neg_en_o    (neg_en_o),
  .dly_gate_no (dly_gate_no),
  .pos_en_o    (pos_en_o),
  .fault_o     (fault_o)
);

// File: tb/test_pwr_seq.sv
`timescale 1ns/1ps
module test_pwr_seq;
  localparam int F = 3;
  localparam int S = 5;
  localparam int L = F + S;
  localparam int TRIP = 10;

  logic clk = 1'b0, rst_n = 1'b0;
  logic en = 0, uvlo = 0, flt = 0, refg = 1, otmp = 0, bg = 1, ng = 1, pgd = 1, dg = 1;
  logic ref_en, pg_n, boost_en, ss, neg_en, dly_n, pos_en, fault;
  int n_chk = 0, n_fail = 0;
  bit done = 0;

  always #10 clk = ~clk;

  pwr_seq #(.FAST_CYC(F), .SLOW_CYC(S), .TRIP_CYC(TRIP)) i_pwr_seq (
    .clk_i(clk), .rst_ni(rst_n), .en_i(en), .uvlo_ok_i(uvlo), .fault_i(flt),
    .ref_good_i(refg), .otemp_i(otmp), .boost_good_i(bg), .neg_good_i(ng),
    .pos_good_i(pgd), .dly_good_i(dg), .ref_en_o(ref_en), .pg_no(pg_n),
    .boost_en_o(boost_en), .soft_start_o(ss), .neg_en_o(neg_en),
    .dly_gate_no(dly_n), .pos_en_o(pos_en), .fault_o(fault)
  );

  // reference model: 0 idle, 1..6 phase, 7 monitor, 8 latched
  int m_st = 0, m_cnt = 0, m_to = 0;
  bit m_ref = 0;

  function automatic bit ph_fail(int ph);
    case (ph)
      1: return flt;
      2: return !refg || otmp;
      6: return flt || !(bg && ng && pgd && dg);
      default: return flt;
    endcase
  endfunction

  always @(posedge clk or negedge rst_n) begin
    if (!rst_n || !en || !uvlo) begin
      m_st = 0; m_cnt = 0; m_to = 0; m_ref = 0;
    end else if (m_st == 0) begin
      m_st = 1; m_cnt = 0;
    end else if (m_st <= 6) begin
      if (ph_fail(m_st) && ((m_st == 6) ? (m_cnt == L-1) : (m_cnt >= F))) m_st = 8;
      else if (m_cnt == L-1) begin
        if (m_st == 1) m_ref = 1;
        m_st = m_st + 1; m_cnt = 0; m_to = 0;
      end else m_cnt++;
    end else if (m_st == 7) begin
      if (flt || otmp || !refg || !bg || !ng || !pgd || !dg) begin
        if (m_to == TRIP-1) m_st = 8;
        else m_to++;
      end else m_to = 0;
    end
  end

  function automatic string tag_of();
    if (m_st == 0) return "R1 R10";
    if (m_st <= 6) return (m_cnt < F) ? "R2 R11" : "R2";
    if (m_st == 7) return "R9";
    return "R8";
  endfunction

  task automatic chk(string nm, string rq, logic act, logic exp);
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s %s [%s] actual=%b expected=%b t=%0t", rq, nm, tag_of(), act, exp, $time);
    end
  endtask

  always @(negedge clk) if (!done) begin
    bit live;
    live = (m_st >= 1 && m_st <= 7);
    chk("ref_en",   "R3 R10", ref_en,   m_ref);
    chk("pg_n",     "R4",     pg_n,     !(live && m_st >= 3));
    chk("boost_en", "R5",     boost_en, live && m_st >= 3);
    chk("soft",     "R5",     ss,       m_st == 3);
    chk("neg_en",   "R6",     neg_en,   live && m_st >= 5);
    chk("dly_n",    "R6",     dly_n,    !(live && m_st >= 6));
    chk("pos_en",   "R7",     pos_en,   live && m_st >= 6);
    chk("fault",    "R8 R9",  fault,    m_st == 8);
  end

  task automatic cyc(int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic restart();
    en = 0; cyc(2); en = 1; cyc(1);
  endtask

  task automatic finish_run();
    done = 1;
    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  endtask

  initial begin
    #(20 * 100000);
    n_chk++; n_fail++;
    $display("FAIL watchdog expired");
    finish_run();
  end

  initial begin
    void'($urandom(32'd20240611));
    cyc(3);
    rst_n = 1;
    cyc(2);
    en = 1; cyc(3);         // R1: no uvlo, stays idle
    uvlo = 1;
    cyc(6 * L + 20);        // R2 clean bring-up into monitor
    restart();
    cyc(1); flt = 1; cyc(1); flt = 0;  // R11: fast-segment fault in phase 1 ignored
    cyc(6 * L + 5);
    restart(); cyc(F + 1); flt = 1; cyc(1); flt = 0; cyc(15); // R3 latch, R8 hold
    restart(); cyc(L + F + 2); refg = 0; cyc(1); refg = 1; cyc(10); // R4
    restart(); cyc(L + 1); otmp = 1; cyc(1); otmp = 0; cyc(10);     // R11: fast segment phase 2
    restart(); cyc(3 * L + F + 1); flt = 1; cyc(1); flt = 0; cyc(10); // R5 phase 4
    restart(); cyc(5 * L + 2); ng = 0; cyc(L); ng = 1; cyc(10);      // R7 peak check
    restart(); cyc(6 * L + 5);
    flt = 1; cyc(TRIP - 1); flt = 0; cyc(5);                         // R9 short glitch
    otmp = 1; cyc(TRIP + 2); otmp = 0; cyc(5);                       // R9 trip
    uvlo = 0; cyc(2); uvlo = 1; cyc(6 * L + 5);                      // R10 uvlo recycle
    en = 0; cyc(1); en = 1; cyc(10);                                 // R10 mid-run drop
    for (int ep = 0; ep < 60; ep++) begin
      int rate;
      rate = (ep % 4 == 0) ? 0 : (ep % 4 == 1) ? 1 : (ep % 4 == 2) ? 4 : 15;
      if ($urandom_range(0, 2) == 0) restart();
      for (int c = 0; c < 90; c++) begin
        @(negedge clk);
        en   = ($urandom_range(0, 999) >= 3);
        uvlo = ($urandom_range(0, 999) >= 2);
        flt  = ($urandom_range(0, 99) < rate);
        otmp = ($urandom_range(0, 99) < rate);
        refg = !($urandom_range(0, 99) < rate);
        bg   = !($urandom_range(0, 99) < rate);
        ng   = !($urandom_range(0, 99) < rate);
        pgd  = !($urandom_range(0, 99) < rate);
        dg   = !($urandom_range(0, 99) < rate);
      end
    end
    cyc(2);
    finish_run();
  end
endmodule